// File: doc/BRIEF.md
# Dual-Mode Cyclic-Mean and Channel Estimate Array

This block is the arithmetic core of a training-based channel estimator. It holds a linear chain of P complex processing elements. First it averages a received block: a feeder presents P parallel complex samples per cycle, NB cycles in a row. Element k accumulates lane k, so the result is the cyclic mean y of a block of N = P·NB samples.

With the mode input set, the same elements then multiply a P×P circulant matrix by y. This yields P channel coefficients, which leave on one bus, one per cycle. Each element uses one shared complex adder. During accumulation a multiplexer feeds the raw sample to that adder and bypasses the multiplier. During the product the adder sums the element's own product with the partial sum arriving from the element before it. The circulant coefficients come from P registers that rotate by one position every clock. No P×P table is stored.

A one-cycle `start` launches a block. The caller chooses, per block, between cyclic mean only and the full estimate.

Top module: `cyclic_est_array`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first block completes, `cm_re`, `cm_im`, `est_re` and `est_im` read zero and `cm_flag`, `done` and `est_valid` are low.
- R2: A `start` seen high at a clock edge while idle opens a block. The sample buses are taken at each of the next NB edges. Lane k (bits k·W to k·W+W−1) of `cm_re`/`cm_im` becomes the two's-complement sum of that lane's NB samples, arithmetically shifted right by log2(NB). The update happens at the NB-th sampling edge.
- R3: With `mode` = 0 latched at start, `cm_flag` is high for exactly the one cycle following the NB-th sampling edge. No `done` or `est_valid` appears for that block.
- R4: With `mode` = 1 latched at start, `est_valid` is high for exactly P consecutive cycles, beginning one edge after the cyclic mean updates. Coefficient i = 0..P−1 is presented in the i-th of those cycles.
- R5: Coefficient i equals the saturated value of (Σj c[(j−i) mod P]·y[j]) >>> F. Each complex product uses four real products (re = a.re·b.re − a.im·b.im, im = a.re·b.im + a.im·b.re). The default row c, in Q(F = 14), is (16383, 0), (8192, −8192), (−4096, 0), (0, 8192) for j = 0..3.
- R6: `done` is a one-cycle pulse that coincides with coefficient 0, one cycle after the product phase begins.
- R7: A `start` that arrives while a block is in progress has no effect on that block's timing or results.
- R8: `cm_re`/`cm_im` hold their value until the next block completes accumulation. `est_re`/`est_im` hold the last coefficient until the next product phase.
- R9: A coefficient whose shifted sum exceeds the signed W-bit range is clamped to 2^(W−1)−1 or −2^(W−1).
- R10: Sample bus values outside the NB sampling edges of a block do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Block launch, honoured only when idle |
| mode | input | 1 | 0 = cyclic mean only, 1 = full estimate |
| smp_re | input | P·W | Real parts of P parallel samples, lane k at bits k·W upward |
| smp_im | input | P·W | Imaginary parts of P parallel samples |
| cm_re | output | P·W | Cyclic-mean real parts, per lane |
| cm_im | output | P·W | Cyclic-mean imaginary parts, per lane |
| cm_flag | output | 1 | Cyclic-mean-only result ready (one cycle) |
| est_re | output | W | Channel coefficient real part |
| est_im | output | W | Channel coefficient imaginary part |
| est_valid | output | 1 | Coefficient on est bus is valid |
| done | output | 1 | Pulse with the first coefficient |

## Verification
The bench builds the array with P = 4, NB = 8, W = 16 and F = 14. With these values a whole block, including the rotation through every circulant column, finishes in about a dozen cycles, so back-to-back blocks, repeated starts during a block and both modes can be covered many times. The 8-cycle mean exercises the floor behaviour of the arithmetic shift on negative sums. A coefficient row whose entries sum above unity lets full-scale samples drive the product into both saturation limits.

// File: rtl/cyclic_est_array.sv
module cyclic_est_array #(
  parameter int P = 4,
  parameter int NB = 8,
  parameter int W = 16,
  parameter int F = 14,
  parameter logic [P*W-1:0] CRE = 64'h0000_F000_2000_3FFF,
  parameter logic [P*W-1:0] CIM = 64'h2000_0000_E000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode,
  input  logic [P*W-1:0] smp_re,
  input  logic [P*W-1:0] smp_im,
  output logic [P*W-1:0] cm_re,
  output logic [P*W-1:0] cm_im,
  output logic           cm_flag,
  output logic [W-1:0]   est_re,
  output logic [W-1:0]   est_im,
  output logic           est_valid,
  output logic           done
);
  localparam int LNB = $clog2(NB);
  localparam int LP  = $clog2(P);
  localparam int AW  = W + LNB;
  localparam int MW  = 2*W + 1;
  localparam int PW  = 2*W + 2 + LP;
  localparam int CW  = $clog2(NB > P ? NB : P) + 1;
  localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  typedef enum logic [1:0] {IDLE, ACC, MVM} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic md;

  wire go   = (st == IDLE) && start;
  wire last = (st == ACC) && (cnt == CW'(NB-1));
  wire accp = (st == ACC);

  logic signed [PW-1:0] ps_re [P+1];
  logic signed [PW-1:0] ps_im [P+1];
  assign ps_re[0] = '0;
  assign ps_im[0] = '0;

  function automatic logic [W-1:0] sat(input logic signed [PW-1:0] v);
    if (v > HI) return HI[W-1:0];
    if (v < LO) return LO[W-1:0];
    return v[W-1:0];
  endfunction

  for (genvar j = 0; j < P; j++) begin : pe
    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [W-1:0]  y_re, y_im, r_re, r_im;
    wire signed [W-1:0] s_re = smp_re[j*W +: W];
    wire signed [W-1:0] s_im = smp_im[j*W +: W];
    wire signed [MW-1:0] m_re = MW'(y_re) * MW'(r_re) - MW'(y_im) * MW'(r_im);
    wire signed [MW-1:0] m_im = MW'(y_re) * MW'(r_im) + MW'(y_im) * MW'(r_re);
    wire signed [PW-1:0] a_re = accp ? PW'(s_re)   : PW'(m_re);
    wire signed [PW-1:0] a_im = accp ? PW'(s_im)   : PW'(m_im);
    wire signed [PW-1:0] b_re = accp ? PW'(acc_re) : ps_re[j];
    wire signed [PW-1:0] b_im = accp ? PW'(acc_im) : ps_im[j];
    assign ps_re[j+1] = a_re + b_re;
    assign ps_im[j+1] = a_im + b_im;
    assign cm_re[j*W +: W] = y_re;
    assign cm_im[j*W +: W] = y_im;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_re <= '0; acc_im <= '0;
        y_re <= '0; y_im <= '0; r_re <= '0; r_im <= '0;
      end else begin
        if (go) begin
          acc_re <= '0; acc_im <= '0;
        end else if (accp) begin
          acc_re <= AW'(ps_re[j+1]); acc_im <= AW'(ps_im[j+1]);
        end
        if (last) begin
          y_re <= W'(ps_re[j+1] >>> LNB);
          y_im <= W'(ps_im[j+1] >>> LNB);
          r_re <= CRE[j*W +: W];
          r_im <= CIM[j*W +: W];
        end else if (st == MVM) begin
          r_re <= pe[(j+P-1)%P].r_re;
          r_im <= pe[(j+P-1)%P].r_im;
        end
      end
    end
  end

  wire signed [PW-1:0] tot_re = ps_re[P] >>> F;
  wire signed [PW-1:0] tot_im = ps_im[P] >>> F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; md <= 1'b0;
      cm_flag <= 1'b0; done <= 1'b0; est_valid <= 1'b0;
      est_re <= '0; est_im <= '0;
    end else begin
      cm_flag <= 1'b0; done <= 1'b0; est_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= ACC; cnt <= '0; md <= mode;
        end
        ACC: begin
          cnt <= cnt + CW'(1);
          if (last) begin
            cnt <= '0;
            if (md) st <= MVM;
            else begin st <= IDLE; cm_flag <= 1'b1; end
          end
        end
        MVM: begin
          est_re <= sat(tot_re);
          est_im <= sat(tot_im);
          est_valid <= 1'b1;
          done <= (cnt == '0);
          cnt <= cnt + CW'(1);
          if (cnt == CW'(P-1)) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cyclic_est_array_chk.sv
module cyclic_est_array_chk #(
  parameter int P = 4,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cm_flag,
  input logic           done,
  input logic           est_valid,
  input logic [P*W-1:0] cm_re,
  input logic [P*W-1:0] cm_im
);
  localparam int RW = $clog2(P + 1) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else run <= est_valid ? run + RW'(1) : '0;
  end

  assert_done_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> est_valid && !$past(est_valid));

  assert_flag_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_flag |-> !est_valid && !done);

  assert_flag_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_flag |=> !cm_flag);

  assert_burst_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> run < RW'(P));

  assert_burst_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(est_valid) |-> run == RW'(P));

  assert_mean_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cm_re) || !$stable(cm_im)) && !cm_flag |=> done);
endmodule

bind cyclic_est_array cyclic_est_array_chk #(.P(P), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cm_flag(cm_flag), .done(done),
  .est_valid(est_valid), .cm_re(cm_re), .cm_im(cm_im)
);

// File: tb/cyclic_est_array_tb_top.sv
module cyclic_est_array_tb_top;
  localparam int P = 4, NB = 8, W = 16, F = 14;
  localparam int LNB = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [P*W-1:0] smp_re, smp_im;
  logic [P*W-1:0] cm_re, cm_im;
  logic cm_flag, done, est_valid;
  logic [W-1:0] est_re, est_im;

  always #4 clk = ~clk;

  cyclic_est_array #(.P(P), .NB(NB), .W(W), .F(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .smp_re(smp_re), .smp_im(smp_im), .cm_re(cm_re), .cm_im(cm_im),
    .cm_flag(cm_flag), .est_re(est_re), .est_im(est_im),
    .est_valid(est_valid), .done(done)
  );

  int cre [P] = '{16383, 8192, -4096, 0};
  int cim [P] = '{0, -8192, 0, 8192};
  int xr [P], xi [P];

  always_comb
    for (int k = 0; k < P; k++) begin
      smp_re[k*W +: W] = W'(xr[k]);
      smp_im[k*W +: W] = W'(xi[k]);
    end

  // behavioural reference
  longint ar [P], ai [P];
  int ey_r [P], ey_i [P];
  int eh_r, eh_i, phase, mcnt, mrow;
  bit mmode, ecm, edone, eev;

  function automatic int sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; mcnt = 0; mrow = 0; mmode = 0; ecm = 0; edone = 0; eev = 0;
      eh_r = 0; eh_i = 0;
      for (int k = 0; k < P; k++) begin ar[k] = 0; ai[k] = 0; ey_r[k] = 0; ey_i[k] = 0; end
    end else begin
      ecm = 0; edone = 0; eev = 0;
      case (phase)
        0: if (start) begin
          phase = 1; mcnt = 0; mmode = mode;
          for (int k = 0; k < P; k++) begin ar[k] = 0; ai[k] = 0; end
        end
        1: begin
          for (int k = 0; k < P; k++) begin ar[k] += xr[k]; ai[k] += xi[k]; end
          if (mcnt == NB - 1) begin
            for (int k = 0; k < P; k++) begin
              ey_r[k] = int'(ar[k] >>> LNB); ey_i[k] = int'(ai[k] >>> LNB);
            end
            if (mmode) begin phase = 2; mrow = 0; end
            else begin phase = 0; ecm = 1; end
          end else mcnt++;
        end
        default: begin
          longint sr, si;
          sr = 0; si = 0;
          for (int j = 0; j < P; j++) begin
            int c;
            c = ((j - mrow) % P + P) % P;
            sr += longint'(ey_r[j]) * cre[c] - longint'(ey_i[j]) * cim[c];
            si += longint'(ey_r[j]) * cim[c] + longint'(ey_i[j]) * cre[c];
          end
          eh_r = sat(sr >>> F); eh_i = sat(si >>> F);
          eev = 1; edone = (mrow == 0);
          mrow++;
          if (mrow == P) phase = 0;
        end
      endcase
    end
  end

  int vectors = 0, miscompares = 0, cycles = 0;
  string scen = "R1 reset";

  task automatic cmp(string fld, string req, longint act, longint exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s actual %0d expected %0d at %0t", req, scen, fld, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string hreq;
    vectors++;
    cmp("cm_flag", "R3", cm_flag, ecm);
    cmp("done", "R6", done, edone);
    cmp("est_valid", "R4", est_valid, eev);
    hreq = (eh_r == 32767 || eh_r == -32768 || eh_i == 32767 || eh_i == -32768) ? "R9" : "R5";
    cmp("est_re", hreq, $signed(est_re), eh_r);
    cmp("est_im", hreq, $signed(est_im), eh_i);
    for (int k = 0; k < P; k++) begin
      cmp($sformatf("cm_re[%0d]", k), "R2", $signed(cm_re[k*W +: W]), ey_r[k]);
      cmp($sformatf("cm_im[%0d]", k), "R2", $signed(cm_im[k*W +: W]), ey_i[k]);
    end
  end

  bit [31:0] lcg = 32'h1234_5678;
  function automatic int rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'($signed(lcg[31:16]));
  endfunction

  task automatic fill(int kind, int r);
    for (int k = 0; k < P; k++) begin
      case (kind)
        0: begin xr[k] = 100 * r + k; xi[k] = -50 * k + r; end
        1: begin xr[k] = rnd(); xi[k] = rnd(); end
        2: begin xr[k] = 32767; xi[k] = 32767; end
        3: begin xr[k] = -32768; xi[k] = -32768; end
        default: begin xr[k] = -(r + k + 1); xi[k] = (r == 0) ? -3 : 0; end
      endcase
    end
  endtask

  task automatic block(bit m, int kind, bit hold_start);
    @(negedge clk); start = 1'b1; mode = m;
    for (int r = 0; r < NB; r++) begin
      @(negedge clk); start = hold_start; mode = ~m; fill(kind, r);
    end
    @(negedge clk); start = 1'b0; fill(1, 0);
    repeat (P + 3) @(negedge clk);
    if (hold_start) repeat (NB + P + 2) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < P; k++) begin xr[k] = 0; xi[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    scen = "R2 R3 ramp mean only";       block(1'b0, 0, 1'b0);
    scen = "R2 R3 negative floor mean";  block(1'b0, 4, 1'b0);
    scen = "R4 R5 R6 random estimate";   block(1'b1, 1, 1'b0);
    scen = "R4 R5 ramp estimate";        block(1'b1, 0, 1'b0);
    scen = "R9 positive saturation";     block(1'b1, 2, 1'b0);
    scen = "R9 negative saturation";     block(1'b1, 3, 1'b0);
    scen = "R7 start held while busy";   block(1'b1, 1, 1'b1);
    scen = "R7 start held mean only";    block(1'b0, 1, 1'b1);
    scen = "R8 R10 idle noise hold";
    for (int c = 0; c < 20; c++) begin @(negedge clk); fill(1, 0); end
    scen = "R5 R6 random estimate 2";    block(1'b1, 1, 1'b0);
    scen = "R2 random mean only";        block(1'b0, 1, 1'b0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired actual %0d expected <= 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule